// File: doc/BRIEF.md
# Sideband register bridge

The bridge sits between a host load/store path and an internal register bus that reaches the chiplet registers of one chip. Each chip owns a fixed-size address window in host space. A 64-bit host access that lands in this chip's window is turned into a register bus address. Two selectable scramblings of the host offset serve two chip generations.

A short table of built-in registers is answered inside the bridge and never reaches the register bus. These are a read-only identification register, a group of registers that read as zero, and a group that silently absorb writes. Every other access goes out through a downstream valid/ready request port, and the host waits until the matching response returns. Each finished access leaves its outcome in two sticky status bits, done and fail. A host-controlled strobe clears them.

The generation select and the chip number are static configuration inputs. Only one access is in flight at any time.

Top module: `sideband_bridge`

## Requirements
- R1: The window base is the generation base plus `cfg_chip_id` times 0x8_0000_0000. The generation base is 0x0003_FC00_0000_0000 when `cfg_gen_new`=0 and 0x0006_03FC_0000_0000 when `cfg_gen_new`=1. An address below the base, or at or above base + 0x8_0000_0000, is rejected. A rejected access completes with fail=1, done=1 and zero read data, and issues no downstream request.
- R2: An access whose `h_size` is not 8 (bytes) is rejected in the same way as in R1.
- R3: With `cfg_gen_new`=1, the register bus address is the window offset shifted right by 3.
- R4: With `cfg_gen_new`=0, register bus address bits [3:0] come from offset bits [6:3]. Address bits [k] for k>=4 come from offset bit [k+4]. Offset bit 7 and offset bits [2:0] are ignored.
- R5: A read of register address 0xF000F returns the `CHIP_IDENT` parameter and is not forwarded.
- R6: Reads of 0x1010C00, 0x1010C03, 0x2020007, 0x2020009, 0x202000F, 0x2013028, 0x201302A, 0x2013801, 0x2013802 and 0x2013F00..0x2013F07 return zero and are not forwarded. Reads of any other address, such as 0x1010C01, are forwarded.
- R7: Writes to 0xF000F, 0x1010C00..0x1010C05, 0x2020007, 0x2020009 and 0x202000F are accepted, dropped and not forwarded. A later identification read is unchanged. Writes to any other address, such as 0x2013F00, are forwarded.
- R8: A forwarded access drives `ds_addr` = register bus address * 8. `ds_valid`, `ds_addr`, `ds_we` and `ds_wdata` hold steady until `ds_ready`. `h_ready` stays low from acceptance until the response is delivered.
- R9: Host data is big-endian. A register value's most significant byte appears in `h_rdata[7:0]`. `ds_wdata` is `h_wdata` with its byte order reversed. Write responses carry zero data.
- R10: Every finished access sets `stat_done`. A downstream response with `ds_rsp_err`=1 also sets `stat_fail` and returns zero data. Both bits are sticky across later accesses.
- R11: `st_clr` clears both status bits on the next edge. When an access finishes on that same edge, its own done and fail values are kept.
- R12: An access answered locally or rejected produces `h_rsp_valid` in the cycle right after acceptance. A forwarded access produces it in the cycle after the downstream response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gen_new | input | 1 | Generation select: 1 = newer translation and base |
| cfg_chip_id | input | CHIP_ID_W | Chip number selecting the window |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Bridge can accept a request |
| h_we | input | 1 | Host request is a store |
| h_addr | input | HADDR_W | Host byte address |
| h_size | input | SIZE_W | Access width in bytes |
| h_wdata | input | DATA_W | Host store data, big-endian |
| h_rsp_valid | output | 1 | One-cycle response pulse |
| h_rdata | output | DATA_W | Host load data, big-endian |
| ds_valid | output | 1 | Downstream request valid |
| ds_ready | input | 1 | Downstream request taken |
| ds_we | output | 1 | Downstream request is a write |
| ds_addr | output | WIN_LOG2 | Downstream byte address |
| ds_wdata | output | DATA_W | Downstream write data |
| ds_rsp_valid | input | 1 | Downstream response valid |
| ds_rdata | input | DATA_W | Downstream read data |
| ds_rsp_err | input | 1 | Downstream response reports failure |
| st_clr | input | 1 | Clear strobe for the status bits |
| stat_done | output | 1 | Sticky completion bit |
| stat_fail | output | 1 | Sticky failure bit |

## Verification
Two functions can fall on the same edge: the status clear strobe and the completion of an access. The bench raises `st_clr` in the very cycle a local or rejected access is accepted, so the clear and the status update land on one edge. It does this once after a failure has made `stat_fail` sticky and the new access succeeds, expecting done=1 and fail=0. It does this again with a rejected access, expecting both bits set. A clear on an idle edge must then bring both bits to zero.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } sbr_state_e;

  localparam logic [63:0] BASE_OLD_DEF = 64'h0003_FC00_0000_0000;
  localparam logic [63:0] BASE_NEW_DEF = 64'h0006_03FC_0000_0000;
  localparam logic [63:0] IDENT_DEF    = 64'h0A1B_2C3D_4E5F_6071;
endpackage

// File: rtl/sbr_xlate.sv
// Window decode and host-offset to register-bus-address scrambling.
module sbr_xlate #(
  parameter int HADDR_W   = 64,
  parameter int WIN_LOG2  = 35,
  parameter int CHIP_ID_W = 6,
  parameter logic [HADDR_W-1:0] BASE_OLD = sbr_pkg::BASE_OLD_DEF,
  parameter logic [HADDR_W-1:0] BASE_NEW = sbr_pkg::BASE_NEW_DEF
) (
  input  logic [HADDR_W-1:0]   addr,
  input  logic                 gen_new,
  input  logic [CHIP_ID_W-1:0] chip_id,
  output logic                 in_win,
  output logic [WIN_LOG2-4:0]  rba
);
  localparam int RBA_W = WIN_LOG2 - 3;

  logic [HADDR_W-1:0] base;
  logic [HADDR_W-1:0] off;
  logic [RBA_W-1:0]   rba_old;
  logic [RBA_W-1:0]   rba_new;

  always_comb begin
    base   = (gen_new ? BASE_NEW : BASE_OLD) + (HADDR_W'(chip_id) << WIN_LOG2);
    off    = addr - base;
    in_win = (addr >= base) && ((off >> WIN_LOG2) == '0);
  end

  // newer generation: plain qword index
  assign rba_new = off[WIN_LOG2-1:3];
  // older generation: bit 7 squeezed out, bits 6:3 form the low nibble
  assign rba_old = {1'b0, off[WIN_LOG2-1:8], off[6:3]};
  assign rba     = gen_new ? rba_new : rba_old;
endmodule

// File: rtl/sbr_local.sv
// Table of registers answered inside the bridge.
module sbr_local #(
  parameter int RBA_W  = 32,
  parameter int DATA_W = 64,
  parameter logic [DATA_W-1:0] IDENT = sbr_pkg::IDENT_DEF
) (
  input  logic [RBA_W-1:0]  rba,
  input  logic              we,
  output logic              hit,
  output logic [DATA_W-1:0] val
);
  localparam logic [RBA_W-1:0] A_IDENT = RBA_W'(32'h000F_000F);
  localparam logic [RBA_W-1:0] A_GA_LO = RBA_W'(32'h0101_0C00);
  localparam logic [RBA_W-1:0] A_GA_M3 = RBA_W'(32'h0101_0C03);
  localparam logic [RBA_W-1:0] A_GA_HI = RBA_W'(32'h0101_0C05);
  localparam logic [RBA_W-1:0] A_GB_7  = RBA_W'(32'h0202_0007);
  localparam logic [RBA_W-1:0] A_GB_9  = RBA_W'(32'h0202_0009);
  localparam logic [RBA_W-1:0] A_GB_F  = RBA_W'(32'h0202_000F);
  localparam logic [RBA_W-1:0] A_GC_LO = RBA_W'(32'h0201_3F00);
  localparam logic [RBA_W-1:0] A_GC_HI = RBA_W'(32'h0201_3F07);
  localparam logic [RBA_W-1:0] A_GD_0  = RBA_W'(32'h0201_3028);
  localparam logic [RBA_W-1:0] A_GD_1  = RBA_W'(32'h0201_302A);
  localparam logic [RBA_W-1:0] A_GD_2  = RBA_W'(32'h0201_3801);
  localparam logic [RBA_W-1:0] A_GD_3  = RBA_W'(32'h0201_3802);

  logic grp_b;
  logic rd_zero;
  logic wr_drop;

  always_comb begin
    grp_b   = (rba == A_GB_7) || (rba == A_GB_9) || (rba == A_GB_F);
    rd_zero = (rba == A_GA_LO) || (rba == A_GA_M3) || grp_b ||
              ((rba >= A_GC_LO) && (rba <= A_GC_HI)) ||
              (rba == A_GD_0) || (rba == A_GD_1) ||
              (rba == A_GD_2) || (rba == A_GD_3);
    wr_drop = (rba == A_IDENT) || grp_b ||
              ((rba >= A_GA_LO) && (rba <= A_GA_HI));
    hit = 1'b0;
    val = '0;
    if (we) begin
      hit = wr_drop;
    end else if (rba == A_IDENT) begin
      hit = 1'b1;
      val = IDENT;
    end else begin
      hit = rd_zero;
    end
  end
endmodule

// File: rtl/sbr_swap.sv
// Byte-order conversion between host lanes and register values.
module sbr_swap #(
  parameter int DATA_W  = 64,
  parameter bit HOST_BE = 1'b1
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NBYTES = DATA_W / 8;

  generate
    if (HOST_BE) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
      end
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate
endmodule

// File: rtl/sideband_bridge.sv
module sideband_bridge #(
  parameter int HADDR_W   = 64,
  parameter int DATA_W    = 64,
  parameter int WIN_LOG2  = 35,
  parameter int CHIP_ID_W = 6,
  parameter int SIZE_W    = 4,
  parameter bit HOST_BE   = 1'b1,
  parameter logic [HADDR_W-1:0] BASE_OLD   = sbr_pkg::BASE_OLD_DEF,
  parameter logic [HADDR_W-1:0] BASE_NEW   = sbr_pkg::BASE_NEW_DEF,
  parameter logic [DATA_W-1:0]  CHIP_IDENT = sbr_pkg::IDENT_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_gen_new,
  input  logic [CHIP_ID_W-1:0] cfg_chip_id,
  input  logic                 h_valid,
  output logic                 h_ready,
  input  logic                 h_we,
  input  logic [HADDR_W-1:0]   h_addr,
  input  logic [SIZE_W-1:0]    h_size,
  input  logic [DATA_W-1:0]    h_wdata,
  output logic                 h_rsp_valid,
  output logic [DATA_W-1:0]    h_rdata,
  output logic                 ds_valid,
  input  logic                 ds_ready,
  output logic                 ds_we,
  output logic [WIN_LOG2-1:0]  ds_addr,
  output logic [DATA_W-1:0]    ds_wdata,
  input  logic                 ds_rsp_valid,
  input  logic [DATA_W-1:0]    ds_rdata,
  input  logic                 ds_rsp_err,
  input  logic                 st_clr,
  output logic                 stat_done,
  output logic                 stat_fail
);
  import sbr_pkg::*;

  localparam int RBA_W     = WIN_LOG2 - 3;
  localparam int ACC_BYTES = DATA_W / 8;

  sbr_state_e         state;
  logic               accept;
  logic               in_win;
  logic               size_ok;
  logic [RBA_W-1:0]   rba;
  logic               loc_hit;
  logic [DATA_W-1:0]  loc_val;
  logic [DATA_W-1:0]  wd_native;
  logic               fin;
  logic               fin_fail;
  logic [DATA_W-1:0]  fin_val;
  logic [DATA_W-1:0]  fin_host;

  sbr_xlate #(
    .HADDR_W(HADDR_W), .WIN_LOG2(WIN_LOG2), .CHIP_ID_W(CHIP_ID_W),
    .BASE_OLD(BASE_OLD), .BASE_NEW(BASE_NEW)
  ) u_xlate (
    .addr(h_addr), .gen_new(cfg_gen_new), .chip_id(cfg_chip_id),
    .in_win(in_win), .rba(rba)
  );

  sbr_local #(.RBA_W(RBA_W), .DATA_W(DATA_W), .IDENT(CHIP_IDENT)) u_local (
    .rba(rba), .we(h_we), .hit(loc_hit), .val(loc_val)
  );

  sbr_swap #(.DATA_W(DATA_W), .HOST_BE(HOST_BE)) u_swap_wr (
    .din(h_wdata), .dout(wd_native)
  );

  sbr_swap #(.DATA_W(DATA_W), .HOST_BE(HOST_BE)) u_swap_rd (
    .din(fin_val), .dout(fin_host)
  );

  assign h_ready = (state == ST_IDLE);
  assign accept  = h_valid && h_ready;
  assign size_ok = (h_size == SIZE_W'(ACC_BYTES));

  // completion decode: local answer, reject, or downstream response
  always_comb begin
    fin      = 1'b0;
    fin_fail = 1'b0;
    fin_val  = '0;
    if (accept) begin
      if (!(in_win && size_ok)) begin
        fin      = 1'b1;
        fin_fail = 1'b1;
      end else if (loc_hit) begin
        fin     = 1'b1;
        fin_val = h_we ? '0 : loc_val;
      end
    end
    if ((state == ST_WAIT) && ds_rsp_valid) begin
      fin      = 1'b1;
      fin_fail = ds_rsp_err;
      fin_val  = (ds_we || ds_rsp_err) ? '0 : ds_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      h_rsp_valid <= 1'b0;
      h_rdata     <= '0;
      ds_valid    <= 1'b0;
      ds_we       <= 1'b0;
      ds_addr     <= '0;
      ds_wdata    <= '0;
      stat_done   <= 1'b0;
      stat_fail   <= 1'b0;
    end else begin
      h_rsp_valid <= fin;
      if (fin) begin
        h_rdata <= fin_host;
      end
      stat_done <= fin | (stat_done & ~st_clr);
      stat_fail <= fin_fail | (stat_fail & ~st_clr);
      unique case (state)
        ST_IDLE: begin
          if (accept && in_win && size_ok && !loc_hit) begin
            state    <= ST_REQ;
            ds_valid <= 1'b1;
            ds_we    <= h_we;
            ds_addr  <= {rba, 3'b000};
            ds_wdata <= wd_native;
          end
        end
        ST_REQ: begin
          if (ds_ready) begin
            ds_valid <= 1'b0;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ds_rsp_valid) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int DATA_W = 64,
  parameter int DS_AW  = 35
) (
  input logic              clk,
  input logic              rst,
  input logic              h_ready,
  input logic              h_rsp_valid,
  input logic [DATA_W-1:0] h_rdata,
  input logic              ds_valid,
  input logic              ds_ready,
  input logic              ds_we,
  input logic [DS_AW-1:0]  ds_addr,
  input logic [DATA_W-1:0] ds_wdata,
  input logic              st_clr,
  input logic              stat_done,
  input logic              stat_fail
);
  a_r8_req_hold: assert property (@(posedge clk) disable iff (rst)
    ds_valid && !ds_ready |=> ds_valid && $stable(ds_addr) && $stable(ds_we) && $stable(ds_wdata));

  a_r8_host_stall: assert property (@(posedge clk) disable iff (rst)
    ds_valid |-> !h_ready);

  a_r10_fail_with_done: assert property (@(posedge clk) disable iff (rst)
    stat_fail |-> stat_done);

  a_r10_fail_zero_data: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_fail) |-> h_rsp_valid && (h_rdata == '0));

  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    st_clr |=> h_rsp_valid || !stat_done);

  a_r12_done_on_rsp: assert property (@(posedge clk) disable iff (rst)
    h_rsp_valid |-> stat_done);
endmodule

bind sideband_bridge sbr_checker #(.DATA_W(DATA_W), .DS_AW(WIN_LOG2)) u_chk (
  .clk(clk), .rst(rst), .h_ready(h_ready), .h_rsp_valid(h_rsp_valid),
  .h_rdata(h_rdata), .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_we(ds_we),
  .ds_addr(ds_addr), .ds_wdata(ds_wdata), .st_clr(st_clr),
  .stat_done(stat_done), .stat_fail(stat_fail)
);

// File: tb/sim_sideband_bridge.sv
`timescale 1ns/1ps
module sim_sideband_bridge;
  localparam logic [63:0] IDENT = 64'h5A69_7887_96A5_B4C3;
  localparam logic [63:0] B_OLD = 64'h0003_FC00_0000_0000;
  localparam logic [63:0] B_NEW = 64'h0006_03FC_0000_0000;
  localparam logic [63:0] WIN   = 64'h0000_0008_0000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_gen_new = 1'b1;
  logic [5:0] cfg_chip_id = 6'd2;
  logic h_valid = 1'b0, h_we = 1'b0;
  logic [63:0] h_addr = '0, h_wdata = '0;
  logic [3:0] h_size = 4'd8;
  logic h_ready, h_rsp_valid;
  logic [63:0] h_rdata;
  logic ds_valid, ds_we;
  logic ds_ready = 1'b0;
  logic [34:0] ds_addr;
  logic [63:0] ds_wdata;
  logic ds_rsp_valid = 1'b0, ds_rsp_err = 1'b0;
  logic [63:0] ds_rdata = '0;
  logic st_clr = 1'b0;
  logic stat_done, stat_fail;

  always #5 clk = ~clk;

  sideband_bridge #(.CHIP_IDENT(IDENT)) u0 (
    .clk(clk), .rst(rst), .cfg_gen_new(cfg_gen_new), .cfg_chip_id(cfg_chip_id),
    .h_valid(h_valid), .h_ready(h_ready), .h_we(h_we), .h_addr(h_addr),
    .h_size(h_size), .h_wdata(h_wdata), .h_rsp_valid(h_rsp_valid),
    .h_rdata(h_rdata), .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_we(ds_we),
    .ds_addr(ds_addr), .ds_wdata(ds_wdata), .ds_rsp_valid(ds_rsp_valid),
    .ds_rdata(ds_rdata), .ds_rsp_err(ds_rsp_err), .st_clr(st_clr),
    .stat_done(stat_done), .stat_fail(stat_fail)
  );

  int total = 0;
  int bad = 0;
  bit sticky = 1'b0;
  logic [63:0] q_rd[$];
  bit q_fail[$];
  string q_tag[$];

  // downstream model knobs and observations
  int ready_dly = 0;
  int rsp_lat = 0;
  bit err_k = 1'b0;
  logic [63:0] rdata_k = 64'h1122_3344_5566_7788;
  int ds_cnt = 0;
  logic [34:0] obs_addr;
  logic obs_we;
  logic [63:0] obs_wdata;

  function automatic logic [63:0] bswap(logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] wbase(bit gen, int id);
    return (gen ? B_NEW : B_OLD) + 64'(id) * WIN;
  endfunction

  function automatic logic [63:0] off_new(logic [31:0] r);
    return 64'(r) << 3;
  endfunction

  function automatic logic [63:0] off_old(logic [31:0] r);
    return (64'(r >> 4) << 8) | (64'(r[3:0]) << 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver: pushes the expected response, then issues one access
  task automatic acc(input logic [63:0] addr, input logic [3:0] size, input bit we,
                     input logic [63:0] wd, input logic [63:0] exp_rd, input bit exp_fail,
                     input bit exp_fwd, input logic [31:0] exp_rba, input bit clr_with,
                     input string tag);
    int c0;
    bit sf;
    c0 = ds_cnt;
    sf = exp_fail | (sticky & !clr_with);
    sticky = sf;
    q_rd.push_back(exp_rd);
    q_fail.push_back(sf);
    q_tag.push_back(tag);
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    h_valid = 1'b1; h_we = we; h_addr = addr; h_size = size; h_wdata = wd;
    st_clr = clr_with;
    @(negedge clk);
    h_valid = 1'b0; st_clr = 1'b0;
    if (!exp_fwd) chk(h_rsp_valid == 1'b1, {tag, " R12 local latency"}, 64'(h_rsp_valid), 64'd1);
    while (q_rd.size() != 0) @(negedge clk);
    chk((ds_cnt - c0) == (exp_fwd ? 1 : 0), {tag, " forward count"}, 64'(ds_cnt - c0), 64'(exp_fwd));
    if (exp_fwd) begin
      chk(obs_addr == {exp_rba, 3'b000}, {tag, " R8 ds_addr"}, 64'(obs_addr), 64'({exp_rba, 3'b000}));
      chk(obs_we == we, {tag, " R8 ds_we"}, 64'(obs_we), 64'(we));
      if (we) chk(obs_wdata == bswap(wd), {tag, " R9 ds_wdata"}, obs_wdata, bswap(wd));
    end
  endtask

  // monitor: scoreboard compare on every response
  always @(negedge clk) begin
    if (!rst && h_rsp_valid) begin
      if (q_rd.size() == 0) begin
        chk(1'b0, "R12 unexpected response", 64'd1, 64'd0);
      end else begin
        logic [63:0] e;
        bit f;
        string t;
        e = q_rd.pop_front();
        f = q_fail.pop_front();
        t = q_tag.pop_front();
        chk(h_rdata == e, {t, " rdata"}, h_rdata, e);
        chk(stat_done == 1'b1, {t, " R10 done"}, 64'(stat_done), 64'd1);
        chk(stat_fail == f, {t, " R10 fail"}, 64'(stat_fail), 64'(f));
      end
    end
  end

  // downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && ds_valid) begin
        repeat (ready_dly) @(negedge clk);
        chk(ds_valid && !h_ready, "R8 held request stalls host", 64'(h_ready), 64'd0);
        ds_ready = 1'b1;
        obs_addr = ds_addr; obs_we = ds_we; obs_wdata = ds_wdata;
        ds_cnt++;
        @(negedge clk);
        ds_ready = 1'b0;
        repeat (rsp_lat) @(negedge clk);
        ds_rsp_valid = 1'b1; ds_rdata = rdata_k; ds_rsp_err = err_k;
        @(negedge clk);
        ds_rsp_valid = 1'b0; ds_rsp_err = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  localparam logic [31:0] RZ [17] = '{32'h0101_0C00, 32'h0101_0C03, 32'h0202_0007,
    32'h0202_0009, 32'h0202_000F, 32'h0201_3F00, 32'h0201_3F01, 32'h0201_3F02,
    32'h0201_3F03, 32'h0201_3F04, 32'h0201_3F05, 32'h0201_3F06, 32'h0201_3F07,
    32'h0201_3028, 32'h0201_302A, 32'h0201_3801, 32'h0201_3802};
  localparam logic [31:0] WD [11] = '{32'h000F_000F, 32'h0101_0C00, 32'h0101_0C01,
    32'h0101_0C02, 32'h0101_0C03, 32'h0101_0C04, 32'h0101_0C05, 32'h0202_0007,
    32'h0202_0009, 32'h0202_000F, 32'h000F_000F};

  initial begin
    logic [63:0] bn, bo;
    bn = wbase(1'b1, 2);
    bo = wbase(1'b0, 2);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(h_ready == 1'b1, "reset h_ready", 64'(h_ready), 64'd1);
    chk(ds_valid == 1'b0, "reset ds_valid", 64'(ds_valid), 64'd0);
    chk({stat_done, stat_fail} == 2'b00, "reset status", 64'({stat_done, stat_fail}), 64'd0);

    // R3, R9: newer generation forward read and write
    acc(bn + off_new(32'h0123_4567), 4'd8, 1'b0, '0, bswap(rdata_k), 1'b0, 1'b1,
        32'h0123_4567, 1'b0, "R3 R9 new read");
    acc(bn + off_new(32'h0000_4321) + 64'd5, 4'd8, 1'b1, 64'h0102_0304_0506_0708, '0, 1'b0, 1'b1,
        32'h0000_4321, 1'b0, "R3 R9 new write low bits");
    // R5, R7: identification register
    acc(bn + off_new(32'h000F_000F), 4'd8, 1'b0, '0, bswap(IDENT), 1'b0, 1'b0, '0, 1'b0, "R5 ident");
    acc(bn + off_new(32'h000F_000F), 4'd8, 1'b1, 64'hFFFF, '0, 1'b0, 1'b0, '0, 1'b0, "R7 ident write");
    acc(bn + off_new(32'h000F_000F), 4'd8, 1'b0, '0, bswap(IDENT), 1'b0, 1'b0, '0, 1'b0, "R7 ident unchanged");
    // R6, R7: built-in tables and their edges
    for (int i = 0; i < 17; i++)
      acc(bn + off_new(RZ[i]), 4'd8, 1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, "R6 zero read");
    for (int i = 0; i < 11; i++)
      acc(bn + off_new(WD[i]), 4'd8, 1'b1, 64'h55, '0, 1'b0, 1'b0, '0, 1'b0, "R7 write drop");
    acc(bn + off_new(32'h0101_0C01), 4'd8, 1'b0, '0, bswap(rdata_k), 1'b0, 1'b1,
        32'h0101_0C01, 1'b0, "R6 non-table read forwards");
    acc(bn + off_new(32'h0201_3F00), 4'd8, 1'b1, 64'hA5, '0, 1'b0, 1'b1,
        32'h0201_3F00, 1'b0, "R7 non-table write forwards");
    // R1: window edges
    acc(bn + WIN - 64'd8, 4'd8, 1'b0, '0, bswap(rdata_k), 1'b0, 1'b1,
        32'hFFFF_FFFF, 1'b0, "R1 last qword");
    acc(bn + WIN, 4'd8, 1'b0, '0, '0, 1'b1, 1'b0, '0, 1'b0, "R1 above window");
    acc(bn - 64'd8, 4'd8, 1'b0, '0, '0, 1'b1, 1'b0, '0, 1'b1, "R1 below window");
    acc(wbase(1'b1, 3), 4'd8, 1'b0, '0, '0, 1'b1, 1'b0, '0, 1'b0, "R1 other chip");
    // R10: sticky fail survives a good access
    acc(bn + off_new(32'h000F_000F), 4'd8, 1'b0, '0, bswap(IDENT), 1'b0, 1'b0, '0, 1'b0, "R10 sticky");
    // R11: clear coinciding with completion
    acc(bn + off_new(32'h000F_000F), 4'd8, 1'b0, '0, bswap(IDENT), 1'b0, 1'b0, '0, 1'b1, "R11 clear with success");
    acc(bn, 4'd4, 1'b0, '0, '0, 1'b1, 1'b0, '0, 1'b1, "R2 R11 clear with reject");
    @(negedge clk);
    st_clr = 1'b1;
    @(negedge clk);
    st_clr = 1'b0;
    sticky = 1'b0;
    chk({stat_done, stat_fail} == 2'b00, "R11 idle clear", 64'({stat_done, stat_fail}), 64'd0);
    // R2: width reject
    acc(bn + 64'h100, 4'd2, 1'b1, 64'h1, '0, 1'b1, 1'b0, '0, 1'b1, "R2 narrow write");
    // R4: older generation
    cfg_gen_new = 1'b0;
    acc(bo + off_old(32'h000F_000F), 4'd8, 1'b0, '0, bswap(IDENT), 1'b0, 1'b0, '0, 1'b1, "R4 old ident");
    acc(bo + off_old(32'h00AB_CDEF), 4'd8, 1'b0, '0, bswap(rdata_k), 1'b0, 1'b1,
        32'h00AB_CDEF, 1'b0, "R4 old forward");
    acc(bo + (off_old(32'h00AB_CDE9) | 64'h84), 4'd8, 1'b0, '0, bswap(rdata_k), 1'b0, 1'b1,
        32'h00AB_CDE9, 1'b0, "R4 old bit7 ignored");
    acc(bo + WIN, 4'd8, 1'b0, '0, '0, 1'b1, 1'b0, '0, 1'b0, "R1 old above window");
    // R8, R10: slow downstream and error responses
    cfg_gen_new = 1'b1;
    ready_dly = 3; rsp_lat = 4; rdata_k = 64'hDEAD_BEEF_0BAD_F00D;
    acc(bn + off_new(32'h0003_0000), 4'd8, 1'b0, '0, bswap(rdata_k), 1'b0, 1'b1,
        32'h0003_0000, 1'b1, "R8 R12 slow read");
    err_k = 1'b1;
    acc(bn + off_new(32'h0003_0008), 4'd8, 1'b0, '0, '0, 1'b1, 1'b1,
        32'h0003_0008, 1'b0, "R10 error read zero data");
    acc(bn + off_new(32'h0003_0010), 4'd8, 1'b1, 64'h77, '0, 1'b1, 1'b1,
        32'h0003_0010, 1'b1, "R10 error write");
    err_k = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule